// File: doc/BRIEF.md
# Silent-Store-Eliminating Cache Write Path

This block is the store side of a small write-back data cache that keeps a four-state coherence tag per line: Invalid, Shared, Exclusive or Modified. Before a store to a clean Shared or Exclusive line is allowed to change the coherence state or set the dirty bit, the block reads the addressed word and compares it with the store data. Only the bytes the byte-enable selects take part in the comparison. When the enabled bytes already hold the stored values, the store retires without effect. The line stays clean, keeps its state and sends no ownership upgrade, so no writeback follows later.

The compare read shares the data array with other users. It runs only in a cycle where the `array_busy` input is low. If the array stays busy for `WAIT_MAX` cycles in a row, the store gives up the compare and takes the ordinary write path. In place of an invalidation, a silent store can raise a lightweight "touched" request so that a watching agent still sees the access. A configuration bit turns this on or off. A second configuration bit limits elimination to stores whose enabled bytes are all zero.

Misses allocate through a read-for-ownership request. A dirty victim first produces a writeback request. A fill port lets the surrounding system install lines in Shared or Exclusive state. A probe port reads back one line's state, dirty bit and data. Two counters report how many stores were eliminated and how many upgrades were issued.

Top module: `silent_store_cache`

## Requirements

The encodings below apply to all requirements.

- Line states: 0 = Invalid, 1 = Shared, 2 = Exclusive, 3 = Modified.
- Bus request types: 0 = writeback, 1 = upgrade, 2 = read-for-ownership, 3 = touched.
- `st_addr` is a word address:
  - bit 0 selects the word within a two-word line;
  - bits 2:1 are the line index;
  - bits 9:3 are the tag.
- A line address is `st_addr[9:1]`, which is {tag, index}.
- Byte-enable bit b covers data bits 8b+7 to 8b.
- Word w sits at line bits 32w+31 to 32w.

- R1: After reset every line is Invalid and clean, both counters are zero, `st_ready` is 1 and `bus_req_valid` is 0.
- R2: Consider a hit on a Shared line where every enabled byte matches, the compare gets an idle array cycle and zero-only mode does not block elimination. The store leaves the line Shared and clean with its data unchanged. It increments `silent_cnt` and issues no upgrade.
- R3: With `cfg_touch_en` = 1, each silent store raises exactly one single-cycle request of type 3 carrying the line address. With `cfg_touch_en` = 0, a silent store raises no bus request.
- R4: A hit on a Shared line that differs in an enabled byte raises a type 1 request. The request holds type and address until `bus_gnt`. The block then writes the enabled bytes, moves the line to Modified and sets it dirty, and `upgrade_cnt` counts the upgrade.
- R5: On an Exclusive line, a differing store writes, moves the line to Modified and sets it dirty with no bus request. A matching store leaves the line Exclusive and clean and counts as silent.
- R6: Bytes whose enable bit is 0 are neither compared nor written. A store with all enables 0 to a Shared or Exclusive line is silent.
- R7: With `cfg_zero_only` = 1, a store is eliminated only when it matches and every enabled byte of its data is zero. Any other store takes the normal path.
- R8: If `array_busy` is high for `WAIT_MAX` (default 3) consecutive compare cycles, the store takes the normal path even if it matches. A shorter busy stretch still allows elimination.
- R9: A miss is never silent.
  - If the victim line is dirty, a single-cycle type 0 request with the victim's line address comes first.
  - A type 2 request then waits for `bus_gnt`.
  - The line is installed from `bus_fill_data` merged with the store's enabled bytes, in Modified state and dirty.
- R10: A hit on a Modified line writes the enabled bytes, stays Modified and dirty, and leaves the bus and both counters untouched.
- R11: A fill installs the given line in the given state, clean, with the given data. Filling over a dirty line first raises a single-cycle type 0 request with the old line address.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_touch_en | input | 1 | Enable touched requests on silent stores |
| cfg_zero_only | input | 1 | Restrict elimination to all-zero store data |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted in this cycle if valid |
| st_addr | input | 10 | Store word address |
| st_be | input | 4 | Store byte enables |
| st_data | input | 32 | Store data |
| array_busy | input | 1 | Data array taken by another user this cycle |
| fill_valid | input | 1 | Install a line (taken when idle, has priority over stores) |
| fill_addr | input | 9 | Line address to install |
| fill_state | input | 2 | State for the installed line |
| fill_data | input | 64 | Data for the installed line |
| bus_req_valid | output | 1 | Bus request active |
| bus_req_type | output | 2 | Request type (0 writeback, 1 upgrade, 2 read-for-ownership, 3 touched) |
| bus_req_addr | output | 9 | Line address of the request |
| bus_gnt | input | 1 | Grant for upgrade and read-for-ownership requests |
| bus_fill_data | input | 64 | Line data returned with a read-for-ownership grant |
| probe_idx | input | 2 | Line index to observe |
| probe_state | output | 2 | State of the probed line |
| probe_dirty | output | 1 | Dirty bit of the probed line |
| probe_data | output | 64 | Data of the probed line |
| silent_cnt | output | 16 | Number of stores eliminated |
| upgrade_cnt | output | 16 | Number of upgrades issued |

## Verification

The assertions assume four things about the inputs:

- `cfg_touch_en` and `cfg_zero_only` stay steady while a store is in flight.
- `bus_gnt` is raised only while an upgrade or read-for-ownership request is pending.
- The grant lasts a single cycle.
- Fill data for a line in Shared or Exclusive state is clean.

The bench changes the configuration only between operations. Its bus stub answers only pending upgrade and read-for-ownership requests, after a random delay, with a one-cycle grant. It drives `array_busy` for a set number of compare cycles chosen for each store. This lets the bench model predict whether the compare gave up.

// File: rtl/silent_store_cache.sv
module silent_store_cache #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 2,
  parameter int NLINES   = 4,
  parameter int WAIT_MAX = 3,
  parameter int CNT_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_touch_en,
  input  logic                           cfg_zero_only,
  input  logic                           st_valid,
  output logic                           st_ready,
  input  logic [ADDR_W-1:0]              st_addr,
  input  logic [DATA_W/8-1:0]            st_be,
  input  logic [DATA_W-1:0]              st_data,
  input  logic                           array_busy,
  input  logic                           fill_valid,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] fill_addr,
  input  logic [1:0]                     fill_state,
  input  logic [DATA_W*WORDS-1:0]        fill_data,
  output logic                           bus_req_valid,
  output logic [1:0]                     bus_req_type,
  output logic [ADDR_W-$clog2(WORDS)-1:0] bus_req_addr,
  input  logic                           bus_gnt,
  input  logic [DATA_W*WORDS-1:0]        bus_fill_data,
  input  logic [$clog2(NLINES)-1:0]      probe_idx,
  output logic [1:0]                     probe_state,
  output logic                           probe_dirty,
  output logic [DATA_W*WORDS-1:0]        probe_data,
  output logic [CNT_W-1:0]               silent_cnt,
  output logic [CNT_W-1:0]               upgrade_cnt
);
  localparam int BE_W    = DATA_W / 8;
  localparam int WOFF_W  = $clog2(WORDS);
  localparam int IDX_W   = $clog2(NLINES);
  localparam int LADDR_W = ADDR_W - WOFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;
  localparam int LINE_W  = DATA_W * WORDS;
  localparam int WCNT_W  = $clog2(WAIT_MAX + 1);

  localparam logic [1:0] L_I = 2'd0, L_S = 2'd1, L_E = 2'd2, L_M = 2'd3;
  localparam logic [1:0] Q_WB = 2'd0, Q_UPG = 2'd1, Q_RFO = 2'd2, Q_TCH = 2'd3;

  typedef enum logic [2:0] {
    F_IDLE, F_CMP, F_UPG, F_WB, F_RFO, F_TCH
  } fsm_t;

  fsm_t                fsm;
  logic [LADDR_W-1:0]  r_laddr, r_wb_addr;
  logic [WOFF_W-1:0]   r_woff;
  logic [BE_W-1:0]     r_be;
  logic [DATA_W-1:0]   r_data;
  logic [WCNT_W-1:0]   wcnt;
  logic                wb_then_rfo;

  logic [TAG_W-1:0]    tag_q   [NLINES];
  logic [1:0]          st_q    [NLINES];
  logic                dirty_q [NLINES];
  logic [LINE_W-1:0]   data_q  [NLINES];

  function automatic logic [DATA_W-1:0] expand(input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < BE_W; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] base,
      input logic [WOFF_W-1:0] woff, input logic [BE_W-1:0] be, input logic [DATA_W-1:0] d);
    logic [LINE_W-1:0] o;
    o = base;
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < BE_W; b++)
        if (int'(woff) == w && be[b]) o[w*DATA_W + b*8 +: 8] = d[b*8 +: 8];
    return o;
  endfunction

  logic [IDX_W-1:0]  r_idx, fill_idx;
  logic [TAG_W-1:0]  r_tag;
  logic [1:0]        cur_st;
  logic              hit, eligible, same, zero_ok, slot_ok, give_up;
  logic              silent_go, normal, normal_s, normal_e;
  logic [DATA_W-1:0] old_word, bmask;
  logic [LINE_W-1:0] new_line, alloc_line;

  assign r_idx      = r_laddr[IDX_W-1:0];
  assign r_tag      = r_laddr[LADDR_W-1:IDX_W];
  assign fill_idx   = fill_addr[IDX_W-1:0];
  assign cur_st     = st_q[r_idx];
  assign hit        = (cur_st != L_I) && (tag_q[r_idx] == r_tag);
  assign eligible   = hit && (cur_st == L_S || cur_st == L_E);
  assign old_word   = data_q[r_idx][r_woff*DATA_W +: DATA_W];
  assign bmask      = expand(r_be);
  assign same       = ((old_word ^ r_data) & bmask) == '0;
  assign zero_ok    = !cfg_zero_only || ((r_data & bmask) == '0);
  assign slot_ok    = !array_busy;
  assign give_up    = array_busy && (wcnt == WCNT_W'(WAIT_MAX - 1));
  assign silent_go  = (fsm == F_CMP) && eligible && slot_ok && same && zero_ok;
  assign normal     = (fsm == F_CMP) && eligible && ((slot_ok && !(same && zero_ok)) || give_up);
  assign normal_s   = normal && (cur_st == L_S);
  assign normal_e   = normal && (cur_st == L_E);
  assign new_line   = merge_line(data_q[r_idx], r_woff, r_be, r_data);
  assign alloc_line = merge_line(bus_fill_data, r_woff, r_be, r_data);

  assign st_ready      = (fsm == F_IDLE) && !fill_valid;
  assign bus_req_valid = (fsm == F_UPG) || (fsm == F_WB) || (fsm == F_RFO) || (fsm == F_TCH);
  assign bus_req_type  = (fsm == F_UPG) ? Q_UPG : (fsm == F_RFO) ? Q_RFO :
                         (fsm == F_TCH) ? Q_TCH : Q_WB;
  assign bus_req_addr  = (fsm == F_WB) ? r_wb_addr : r_laddr;
  assign probe_state   = st_q[probe_idx];
  assign probe_dirty   = dirty_q[probe_idx];
  assign probe_data    = data_q[probe_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm         <= F_IDLE;
      r_laddr     <= '0;
      r_wb_addr   <= '0;
      r_woff      <= '0;
      r_be        <= '0;
      r_data      <= '0;
      wcnt        <= '0;
      wb_then_rfo <= 1'b0;
      silent_cnt  <= '0;
      upgrade_cnt <= '0;
      for (int i = 0; i < NLINES; i++) begin
        tag_q[i]   <= '0;
        st_q[i]    <= L_I;
        dirty_q[i] <= 1'b0;
        data_q[i]  <= '0;
      end
    end else begin
      case (fsm)
        F_IDLE: begin
          if (fill_valid) begin
            if (dirty_q[fill_idx]) begin
              r_wb_addr   <= {tag_q[fill_idx], fill_idx};
              wb_then_rfo <= 1'b0;
              fsm         <= F_WB;
            end
            tag_q[fill_idx]   <= fill_addr[LADDR_W-1:IDX_W];
            st_q[fill_idx]    <= fill_state;
            dirty_q[fill_idx] <= 1'b0;
            data_q[fill_idx]  <= fill_data;
          end else if (st_valid) begin
            r_laddr <= st_addr[ADDR_W-1:WOFF_W];
            r_woff  <= st_addr[WOFF_W-1:0];
            r_be    <= st_be;
            r_data  <= st_data;
            wcnt    <= '0;
            fsm     <= F_CMP;
          end
        end
        F_CMP: begin
          if (!hit) begin
            if (dirty_q[r_idx]) begin
              r_wb_addr   <= {tag_q[r_idx], r_idx};
              wb_then_rfo <= 1'b1;
              fsm         <= F_WB;
            end else begin
              fsm <= F_RFO;
            end
          end else if (cur_st == L_M) begin
            data_q[r_idx] <= new_line;
            fsm           <= F_IDLE;
          end else if (silent_go) begin
            silent_cnt <= silent_cnt + CNT_W'(1);
            fsm        <= cfg_touch_en ? F_TCH : F_IDLE;
          end else if (normal_s) begin
            upgrade_cnt <= upgrade_cnt + CNT_W'(1);
            fsm         <= F_UPG;
          end else if (normal_e) begin
            data_q[r_idx]  <= new_line;
            st_q[r_idx]    <= L_M;
            dirty_q[r_idx] <= 1'b1;
            fsm            <= F_IDLE;
          end else begin
            wcnt <= wcnt + WCNT_W'(1);
          end
        end
        F_UPG: if (bus_gnt) begin
          data_q[r_idx]  <= new_line;
          st_q[r_idx]    <= L_M;
          dirty_q[r_idx] <= 1'b1;
          fsm            <= F_IDLE;
        end
        F_WB: fsm <= wb_then_rfo ? F_RFO : F_IDLE;
        F_RFO: if (bus_gnt) begin
          data_q[r_idx]  <= alloc_line;
          tag_q[r_idx]   <= r_tag;
          st_q[r_idx]    <= L_M;
          dirty_q[r_idx] <= 1'b1;
          fsm            <= F_IDLE;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  p_silent_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    silent_go |=> (cur_st == $past(cur_st)) && !dirty_q[r_idx]);

  p_touch_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_type == Q_TCH) |-> $past(cfg_touch_en));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && (bus_req_type == Q_UPG || bus_req_type == Q_RFO) && !bus_gnt)
      |=> bus_req_valid && $stable(bus_req_type) && $stable(bus_req_addr));

  p_upg_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_type == Q_UPG) |-> (hit && cur_st == L_S));

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_CMP && eligible) |-> (wcnt < WCNT_W'(WAIT_MAX)));

  p_miss_not_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_cnt != $past(silent_cnt)) |-> $past(hit));

  p_modified_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm == F_CMP && hit && cur_st == L_M) |-> dirty_q[r_idx]);
endmodule

// File: tb/silent_store_cache_bench.sv
module silent_store_cache_bench;
  localparam int WAIT_MAX = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_touch_en = 1'b1, cfg_zero_only = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [9:0]  st_addr = '0;
  logic [3:0]  st_be = '0;
  logic [31:0] st_data = '0;
  logic        array_busy = 1'b0;
  logic        fill_valid = 1'b0;
  logic [8:0]  fill_addr = '0;
  logic [1:0]  fill_state = '0;
  logic [63:0] fill_data = '0;
  logic        bus_req_valid;
  logic [1:0]  bus_req_type;
  logic [8:0]  bus_req_addr;
  logic        bus_gnt = 1'b0;
  logic [63:0] bus_fill_data = '0;
  logic [1:0]  probe_idx = '0;
  logic [1:0]  probe_state;
  logic        probe_dirty;
  logic [63:0] probe_data;
  logic [15:0] silent_cnt, upgrade_cnt;

  silent_store_cache u_silent_store_cache (
    .clk, .rst_n, .cfg_touch_en, .cfg_zero_only, .st_valid, .st_ready, .st_addr,
    .st_be, .st_data, .array_busy, .fill_valid, .fill_addr, .fill_state, .fill_data,
    .bus_req_valid, .bus_req_type, .bus_req_addr, .bus_gnt, .bus_fill_data,
    .probe_idx, .probe_state, .probe_dirty, .probe_data, .silent_cnt, .upgrade_cnt);

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int n_touch = 0, n_wb = 0, n_rfo = 0, n_upg = 0;
  logic [8:0] last_touch, last_wb;
  int e_silent = 0, e_upg = 0, e_touch = 0, e_wb = 0, e_rfo = 0;
  logic [1:0]  m_state [4];
  logic        m_dirty [4];
  logic [6:0]  m_tag   [4];
  logic [63:0] m_data  [4];
  bit done = 0;

  function automatic logic [63:0] memfn(input logic [8:0] la);
    return {32'(la) * 32'h2545F491 ^ 32'hA5A50000, 32'(la) * 32'h9E3779B1 ^ 32'h00005A5A};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] l, input bit w,
                                        input logic [3:0] be, input logic [31:0] d);
    logic [63:0] o = l;
    for (int b = 0; b < 4; b++) if (be[b]) o[w*32 + b*8 +: 8] = d[b*8 +: 8];
    return o;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    if (bus_req_valid && bus_req_type == 2'd3) begin n_touch++; last_touch = bus_req_addr; end
    if (bus_req_valid && bus_req_type == 2'd0) begin n_wb++; last_wb = bus_req_addr; end
    if (bus_req_valid && bus_gnt && bus_req_type == 2'd1) n_upg++;
    if (bus_req_valid && bus_gnt && bus_req_type == 2'd2) n_rfo++;
  end

  initial forever begin
    @(negedge clk);
    if (bus_req_valid && (bus_req_type == 2'd1 || bus_req_type == 2'd2)) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      bus_fill_data = memfn(bus_req_addr);
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
    end
  end

  task automatic wait_idle();
    while (!st_ready) @(negedge clk);
  endtask

  task automatic check_all(input string req, input int idx);
    probe_idx = 2'(idx);
    #1;
    check({req, " state"}, 64'(probe_state), 64'(m_state[idx]));
    check({req, " dirty"}, 64'(probe_dirty), 64'(m_dirty[idx]));
    check({req, " data"}, probe_data, m_data[idx]);
    check({req, " silent_cnt"}, 64'(silent_cnt), 64'(e_silent));
    check({req, " upgrade_cnt"}, 64'(upgrade_cnt), 64'(e_upg));
    check({req, " bus upgrades"}, 64'(n_upg), 64'(e_upg));
    check({req, " touched"}, 64'(n_touch), 64'(e_touch));
    check({req, " writebacks"}, 64'(n_wb), 64'(e_wb));
    check({req, " rfo"}, 64'(n_rfo), 64'(e_rfo));
  endtask

  task automatic do_fill(input string note, input logic [8:0] la, input logic [1:0] s,
                         input logic [63:0] d);
    int idx = int'(la[1:0]);
    wait_idle();
    fill_addr = la; fill_state = s; fill_data = d; fill_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    if (m_dirty[idx]) e_wb++;
    m_state[idx] = s; m_dirty[idx] = 1'b0; m_tag[idx] = la[8:2]; m_data[idx] = d;
    wait_idle();
    check_all({note, " R11 fill"}, idx);
  endtask

  task automatic do_store(input string note, input logic [9:0] a, input logic [3:0] be,
                          input logic [31:0] d, input int k);
    int idx = int'(a[2:1]);
    bit w = a[0];
    string path;
    logic [31:0] m = 32'h0;
    bit hit, match;
    for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
    hit = (m_state[idx] != 2'd0) && (m_tag[idx] == a[9:3]);
    match = (((m_data[idx][w*32 +: 32] ^ d) & m) == 0) && (!cfg_zero_only || ((d & m) == 0));
    if (!hit) begin
      path = "R9";
      if (m_dirty[idx]) e_wb++;
      e_rfo++;
      m_data[idx] = merge(memfn(a[9:1]), w, be, d);
      m_tag[idx] = a[9:3]; m_state[idx] = 2'd3; m_dirty[idx] = 1'b1;
    end else if (m_state[idx] == 2'd3) begin
      path = "R10";
      m_data[idx] = merge(m_data[idx], w, be, d);
    end else if (match && k < WAIT_MAX) begin
      path = (m_state[idx] == 2'd1) ? "R2" : "R5";
      e_silent++;
      if (cfg_touch_en) e_touch++;
    end else begin
      path = (m_state[idx] == 2'd1) ? "R4" : "R5";
      if (m_state[idx] == 2'd1) e_upg++;
      m_data[idx] = merge(m_data[idx], w, be, d);
      m_state[idx] = 2'd3; m_dirty[idx] = 1'b1;
    end
    wait_idle();
    st_addr = a; st_be = be; st_data = d; st_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    for (int j = 0; j < k; j++) begin array_busy = 1'b1; @(negedge clk); end
    array_busy = 1'b0;
    wait_idle();
    check_all({note, " ", path}, idx);
  endtask

  initial begin
    logic [63:0] dat;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      m_state[i] = 2'd0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 st_ready", 64'(st_ready), 64'd1);
    check("R1 bus_req_valid", 64'(bus_req_valid), 64'd0);
    check_all("R1 reset", 0);
    for (int i = 1; i < 4; i++) check_all("R1 reset", i);

    dat = 64'h1122334455667788;
    do_fill("dir", 9'h004, 2'd1, dat);
    do_store("R3 touch on", 10'h008, 4'hF, 32'h55667788, 0);
    check("R3 touch address", 64'(last_touch), 64'h004);
    cfg_touch_en = 1'b0;
    do_store("R3 touch off", 10'h008, 4'hF, 32'h55667788, 0);
    cfg_touch_en = 1'b1;
    do_store("R6 masked match", 10'h009, 4'b0101, 32'hFF22FF44, 0);
    do_store("R4 differ", 10'h009, 4'b0010, 32'h0000AB00, 0);
    do_store("R10 modified hit", 10'h008, 4'b1000, 32'hCD000000, 0);
    do_fill("dir", 9'h00D, 2'd2, 64'hCAFEF00D0BADBEEF);
    do_store("R5 exclusive match", 10'h01B, 4'hF, 32'hCAFEF00D, 0);
    do_store("R5 exclusive differ", 10'h01A, 4'b0001, 32'h00000000, 0);
    do_fill("dir", 9'h00E, 2'd1, 64'h0000000012345678);
    do_store("R6 no enables", 10'h01C, 4'h0, 32'hDEADBEEF, 0);
    cfg_zero_only = 1'b1;
    do_store("R7 zero match", 10'h01D, 4'hF, 32'h00000000, 0);
    do_store("R7 nonzero match", 10'h01C, 4'hF, 32'h12345678, 0);
    cfg_zero_only = 1'b0;
    do_fill("R11 dirty victim", 9'h016, 2'd1, 64'h0F0F0F0FA0A0A0A0);
    check("R11 victim address", 64'(last_wb), 64'h00E);
    do_store("R8 busy full", 10'h02C, 4'hF, 32'hA0A0A0A0, 3);
    do_fill("dir", 9'h016, 2'd1, 64'h0F0F0F0FA0A0A0A0);
    do_store("R8 busy short", 10'h02C, 4'hF, 32'hA0A0A0A0, 2);
    do_store("R9 miss dirty victim", 10'h028, 4'b0011, 32'h0000BEEF, 0);
    check("R9 victim address", 64'(last_wb), 64'h004);
    do_store("R9 miss clean", 10'h03E, 4'hF, 32'h01020304, 0);

    for (int n = 0; n < 300; n++) begin
      int idx = $urandom_range(0, 3);
      bit w = 1'($urandom_range(0, 1));
      logic [6:0] tg = ($urandom_range(0, 9) < 7) ? m_tag[idx] : 7'($urandom_range(0, 3));
      logic [3:0] be = 4'($urandom);
      logic [31:0] d;
      int r = $urandom_range(0, 9);
      cfg_touch_en = ($urandom_range(0, 3) != 0);
      cfg_zero_only = ($urandom_range(0, 4) == 0);
      if (r < 1) begin
        d = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
        do_fill("rand", {tg, 2'(idx)}, ($urandom_range(0, 1) != 0) ? 2'd1 : 2'd2,
                {$urandom, d});
      end else begin
        if (r < 6) d = m_data[idx][w*32 +: 32] ^ (32'($urandom) & ~{{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}});
        else if (r < 7) d = 32'h0;
        else d = $urandom;
        do_store("rand", {tg, 2'(idx), w}, be, d, $urandom_range(0, 4));
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule